// File: doc/BRIEF.md
# Filter Coefficient Byte-Access Port

This block holds the coefficient storage for a pair of IIR equaliser filters. It lets a host load and inspect that storage one byte at a time through two registers per filter: a byte pointer and a data window. Each filter keeps 5 bands of 5 coefficients. Every coefficient is 30 bits wide and occupies four consecutive byte addresses. A write to the data window stores a byte and then moves the pointer forward, so a whole band can be streamed in after a single pointer write. A read of the data window leaves the pointer where it is, so software sets the pointer again before each byte it reads back.

On the other side, the filter datapath reads a full 30-bit coefficient for any (band, index) pair. The result appears one cycle after the request. A host data write to a filter takes precedence over a datapath read of that same filter in the same cycle.

Top module: `coef_mem_port`

## Requirements
- R1: Host address bit 6 selects the filter and bits 5:0 select the register; offset 0 is the pointer. Writing the pointer keeps bits 6:0 of the written byte. Reading it returns the pointer with bit 7 zero.
- R2: A write to the data window (offset 1) stores the byte at the filter's current pointer and then adds one to that pointer.
- R3: A host read produces host_rvalid with host_rdata exactly one cycle later. A data-window read returns the byte at the pointer and leaves the pointer unchanged.
- R4: The byte address of a coefficient is (band*5 + index)*4 + k, where byte k=0 is the least significant byte.
- R5: In byte k=3 of each coefficient only bits 5:0 are kept. Bits 7:6 always read back as zero.
- R6: The pointer wraps from 127 to 0 when a data write advances it.
- R7: Byte addresses 100 to 127 hold no storage. Writes there are dropped but still advance the pointer, and reads there return zero.
- R8: The two filters have separate pointers and separate storage, and neither is affected by accesses to the other.
- R9: A datapath read returns dp_valid and the 30-bit coefficient one cycle later. If band or index is 5 or more, it returns zero.
- R10: A host data-window write to the filter named by a datapath read in the same cycle cancels that read, so no dp_valid follows. The write still completes. A datapath read of the other filter proceeds.
- R11: After reset both pointers are 0, and host_rvalid and dp_valid are low.
- R12: Register offsets 2 to 63 ignore writes and read as zero. When host_wr and host_rd are both high, only the write is performed and no read data follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 7 | Bit 6 filter, bits 5:0 register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | host_rdata valid |
| dp_rd | input | 1 | Datapath read request |
| dp_flt | input | 1 | Datapath filter select |
| dp_band | input | 3 | Band number |
| dp_idx | input | 3 | Coefficient index within the band |
| dp_coef | output | 30 | Assembled coefficient |
| dp_valid | output | 1 | dp_coef valid |

## Verification
The two functions that can land in the same cycle are a host data-window write and a datapath coefficient read. The bench drives both in one cycle, first on the same filter and then on different filters. When they target the same filter, the scoreboard expects no datapath result, and any dp_valid that arrives counts as a failure. A read of that coefficient issued afterwards must then show the newly written byte. When they target different filters, the coefficient must arrive unchanged and on time.

// File: rtl/coefmem_pkg.sv
package coefmem_pkg;
  // kind of host read scheduled for the following cycle
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PTR  = 2'd1,
    RD_DATA = 2'd2,
    RD_ZERO = 2'd3
  } rd_kind_t;

  localparam int BYTES_PER_COEF = 4;
endpackage

// File: rtl/coef_lane_ram.sv
module coef_lane_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 25,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[raddr_a];
    qb <= mem[raddr_b];
  end
endmodule

// File: rtl/coef_filter_bank.sv
module coef_filter_bank #(
  parameter int WORDS   = 25,
  parameter int WORD_AW = 5,
  parameter int COEF_W  = 30
) (
  input  logic               clk,
  input  logic               we,
  input  logic [1:0]         wlane,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [7:0]         wbyte,
  input  logic [WORD_AW-1:0] haddr,
  input  logic [WORD_AW-1:0] daddr,
  output logic [31:0]        hq,
  output logic [COEF_W-1:0]  dq
);
  localparam int TOP_W = COEF_W - 24;

  for (genvar l = 0; l < coefmem_pkg::BYTES_PER_COEF; l++) begin : g_lane
    localparam int LW = (l == 3) ? TOP_W : 8;
    logic [LW-1:0] qa_l, qb_l;

    coef_lane_ram #(.W(LW), .DEPTH(WORDS), .AW(WORD_AW)) u_ram (
      .clk     (clk),
      .we      (we && (wlane == 2'(l))),
      .waddr   (waddr),
      .wdata   (wbyte[LW-1:0]),
      .raddr_a (haddr),
      .raddr_b (daddr),
      .qa      (qa_l),
      .qb      (qb_l)
    );

    if (l == 3) begin : g_top
      assign hq[31:24] = {{(32 - COEF_W){1'b0}}, qa_l};
    end else begin : g_low
      assign hq[l*8 +: 8] = qa_l;
    end
    assign dq[l*8 +: LW] = qb_l;
  end
endmodule

// File: rtl/coef_host_regs.sv
module coef_host_regs #(
  parameter int N_FILT     = 2,
  parameter int PTR_W      = 7,
  parameter int WIN_AW     = 6,
  parameter int BYTES_USED = 100,
  parameter int WORD_AW    = 5,
  localparam int FLT_W     = $clog2(N_FILT),
  localparam int HA_W      = FLT_W + WIN_AW
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           host_wr,
  input  logic                           host_rd,
  input  logic [HA_W-1:0]                host_addr,
  input  logic [7:0]                     host_wdata,
  output logic [N_FILT-1:0][PTR_W-1:0]   ptr_o,
  output logic [N_FILT-1:0]              data_wr_o,
  output logic [N_FILT-1:0]              mem_we_o,
  output logic [N_FILT-1:0][WORD_AW-1:0] word_o,
  output coefmem_pkg::rd_kind_t          rd_kind_q,
  output logic [FLT_W-1:0]               rd_flt_q,
  output logic [1:0]                     rd_lane_q,
  output logic [PTR_W-1:0]               rd_ptr_q
);
  import coefmem_pkg::*;

  logic [FLT_W-1:0]  flt;
  logic [WIN_AW-1:0] off;
  logic              is_ptr, is_data, rd_go;
  logic [N_FILT-1:0] ptr_wr;
  logic [N_FILT-1:0][PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0]  ptr_sel;

  assign flt     = host_addr[HA_W-1 -: FLT_W];
  assign off     = host_addr[WIN_AW-1:0];
  assign is_ptr  = (off == WIN_AW'(0));
  assign is_data = (off == WIN_AW'(1));
  assign rd_go   = host_rd && !host_wr;    // write wins
  assign ptr_sel = ptr_q[flt];

  for (genvar f = 0; f < N_FILT; f++) begin : g_flt
    logic in_range;
    assign in_range     = (ptr_q[f] < PTR_W'(BYTES_USED));
    assign ptr_wr[f]    = host_wr && is_ptr  && (flt == FLT_W'(f));
    assign data_wr_o[f] = host_wr && is_data && (flt == FLT_W'(f));
    assign mem_we_o[f]  = data_wr_o[f] && in_range;
    assign word_o[f]    = in_range ? WORD_AW'(ptr_q[f] >> 2) : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[f] <= '0;
      end else if (ptr_wr[f]) begin
        ptr_q[f] <= host_wdata[PTR_W-1:0];
      end else if (data_wr_o[f]) begin
        ptr_q[f] <= ptr_q[f] + PTR_W'(1);   // natural wrap at 2**PTR_W
      end
    end
  end

  assign ptr_o = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_kind_q <= RD_NONE;
      rd_flt_q  <= '0;
      rd_lane_q <= '0;
      rd_ptr_q  <= '0;
    end else begin
      rd_flt_q  <= flt;
      rd_lane_q <= ptr_sel[1:0];
      rd_ptr_q  <= ptr_sel;
      if (!rd_go)
        rd_kind_q <= RD_NONE;
      else if (is_ptr)
        rd_kind_q <= RD_PTR;
      else if (is_data && (ptr_sel < PTR_W'(BYTES_USED)))
        rd_kind_q <= RD_DATA;
      else
        rd_kind_q <= RD_ZERO;
    end
  end
endmodule

// File: rtl/coef_mem_port.sv
module coef_mem_port #(
  parameter int N_FILT  = 2,
  parameter int N_BAND  = 5,
  parameter int N_COEF  = 5,
  parameter int COEF_W  = 30,
  parameter int PTR_W   = 7,
  parameter int WIN_AW  = 6,
  localparam int FLT_W      = $clog2(N_FILT),
  localparam int HA_W       = FLT_W + WIN_AW,
  localparam int BAND_W     = $clog2(N_BAND),
  localparam int IDX_W      = $clog2(N_COEF),
  localparam int WORDS      = N_BAND * N_COEF,
  localparam int WORD_AW    = $clog2(WORDS),
  localparam int BYTES_USED = WORDS * coefmem_pkg::BYTES_PER_COEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  input  logic              dp_rd,
  input  logic [FLT_W-1:0]  dp_flt,
  input  logic [BAND_W-1:0] dp_band,
  input  logic [IDX_W-1:0]  dp_idx,
  output logic [COEF_W-1:0] dp_coef,
  output logic              dp_valid
);
  import coefmem_pkg::*;

  logic [N_FILT-1:0][PTR_W-1:0]   ptr;
  logic [N_FILT-1:0]              data_wr, mem_we;
  logic [N_FILT-1:0][WORD_AW-1:0] hword;
  rd_kind_t                       rd_kind_q;
  logic [FLT_W-1:0]               rd_flt_q;
  logic [1:0]                     rd_lane_q;
  logic [PTR_W-1:0]               rd_ptr_q;

  coef_host_regs #(
    .N_FILT(N_FILT), .PTR_W(PTR_W), .WIN_AW(WIN_AW),
    .BYTES_USED(BYTES_USED), .WORD_AW(WORD_AW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .ptr_o      (ptr),
    .data_wr_o  (data_wr),
    .mem_we_o   (mem_we),
    .word_o     (hword),
    .rd_kind_q  (rd_kind_q),
    .rd_flt_q   (rd_flt_q),
    .rd_lane_q  (rd_lane_q),
    .rd_ptr_q   (rd_ptr_q)
  );

  // datapath address
  logic               dp_in_range;
  logic [WORD_AW-1:0] dp_word;
  assign dp_in_range = (32'(dp_band) < N_BAND) && (32'(dp_idx) < N_COEF);
  assign dp_word     = dp_in_range ? WORD_AW'(32'(dp_band) * N_COEF + 32'(dp_idx)) : '0;

  logic [N_FILT-1:0][31:0]       hq_all;
  logic [N_FILT-1:0][COEF_W-1:0] dq_all;

  for (genvar f = 0; f < N_FILT; f++) begin : g_bank
    coef_filter_bank #(.WORDS(WORDS), .WORD_AW(WORD_AW), .COEF_W(COEF_W)) u_bank (
      .clk   (clk),
      .we    (mem_we[f]),
      .wlane (ptr[f][1:0]),
      .waddr (hword[f]),
      .wbyte (host_wdata),
      .haddr (hword[f]),
      .daddr (dp_word),
      .hq    (hq_all[f]),
      .dq    (dq_all[f])
    );
  end

  // datapath result tracking: host write to same filter cancels the read
  logic             dp_valid_q, dp_zero_q;
  logic [FLT_W-1:0] dp_flt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid_q <= 1'b0;
      dp_zero_q  <= 1'b0;
      dp_flt_q   <= '0;
    end else begin
      dp_valid_q <= dp_rd && !data_wr[dp_flt];
      dp_zero_q  <= !dp_in_range;
      dp_flt_q   <= dp_flt;
    end
  end

  assign dp_valid = dp_valid_q;
  assign dp_coef  = (dp_valid_q && !dp_zero_q) ? dq_all[dp_flt_q] : '0;

  // host read data
  logic [31:0] hsel;
  assign hsel = hq_all[rd_flt_q];

  always_comb begin
    unique case (rd_kind_q)
      RD_PTR:  host_rdata = 8'(rd_ptr_q);
      RD_DATA: host_rdata = hsel[rd_lane_q*8 +: 8];
      default: host_rdata = 8'h00;
    endcase
  end
  assign host_rvalid = (rd_kind_q != RD_NONE);
endmodule

// File: rtl/coef_mem_port_chk.sv
module coef_mem_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic        host_rd,
  input logic [6:0]  host_addr,
  input logic [7:0]  host_rdata,
  input logic        host_rvalid,
  input logic        dp_rd,
  input logic        dp_flt,
  input logic [2:0]  dp_band,
  input logic [29:0] dp_coef,
  input logic        dp_valid
);
  logic same_flt_wr;
  assign same_flt_wr = host_wr && (host_addr[5:0] == 6'd1) && (host_addr[6] == dp_flt);

  assert_rd_resp_R3: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> host_rvalid);

  assert_no_rd_resp_R12: assert property (@(posedge clk) disable iff (rst)
    (!host_rd || host_wr) |=> !host_rvalid);

  assert_ptr_msb_R1: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && host_addr[5:0] == 6'd0) |=> (host_rdata[7] == 1'b0));

  assert_dp_resp_R9: assert property (@(posedge clk) disable iff (rst)
    (dp_rd && !same_flt_wr) |=> dp_valid);

  assert_dp_oob_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (dp_rd && dp_band >= 3'd5) |=> (dp_coef == 30'd0));

  assert_dp_cancel_R10: assert property (@(posedge clk) disable iff (rst)
    (dp_rd && same_flt_wr) |=> !dp_valid);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!host_rvalid && !dp_valid));
endmodule

bind coef_mem_port coef_mem_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .dp_rd       (dp_rd),
  .dp_flt      (dp_flt),
  .dp_band     (dp_band),
  .dp_coef     (dp_coef),
  .dp_valid    (dp_valid)
);

// File: tb/tb_coef_mem_port.sv
module tb_coef_mem_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        dp_rd = 1'b0, dp_flt = 1'b0;
  logic [2:0]  dp_band = '0, dp_idx = '0;
  logic [29:0] dp_coef;
  logic        dp_valid;

  always #10 clk = ~clk;   // 50 MHz

  coef_mem_port dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dp_rd(dp_rd), .dp_flt(dp_flt),
    .dp_band(dp_band), .dp_idx(dp_idx), .dp_coef(dp_coef), .dp_valid(dp_valid)
  );

  // reference model
  logic [7:0] mem_m [2][128];
  logic [6:0] ptr_m [2];

  logic [31:0] hq_exp[$];
  string       hq_tag[$];
  logic [31:0] dq_exp[$];
  string       dq_tag[$];

  int checks = 0;
  int fails  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; dp_rd = 1'b0;
  endtask

  task automatic hw(bit f, logic [5:0] off, logic [7:0] d);
    host_wr = 1'b1; host_addr = {f, off}; host_wdata = d;
    if (off == 6'd0) ptr_m[f] = d[6:0];
    else if (off == 6'd1) begin
      if (ptr_m[f] < 7'd100) mem_m[f][ptr_m[f]] = (ptr_m[f][1:0] == 2'd3) ? (d & 8'h3F) : d;
      ptr_m[f] = ptr_m[f] + 7'd1;
    end
  endtask

  task automatic hr(bit f, logic [5:0] off, string tag);
    logic [7:0] e;
    host_rd = 1'b1; host_addr = {f, off};
    if (off == 6'd0) e = {1'b0, ptr_m[f]};
    else if (off == 6'd1) e = (ptr_m[f] < 7'd100) ? mem_m[f][ptr_m[f]] : 8'h00;
    else e = 8'h00;
    hq_exp.push_back(32'(e)); hq_tag.push_back(tag);
  endtask

  task automatic dpr(bit f, int band, int idx, bit drop, string tag);
    logic [31:0] e;
    int b;
    dp_rd = 1'b1; dp_flt = f; dp_band = 3'(band); dp_idx = 3'(idx);
    if (band < 5 && idx < 5) begin
      b = (band * 5 + idx) * 4;
      e = {2'b00, mem_m[f][b+3][5:0], mem_m[f][b+2], mem_m[f][b+1], mem_m[f][b]};
    end else e = 32'd0;
    if (!drop) begin dq_exp.push_back(e); dq_tag.push_back(tag); end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (host_rvalid) begin
        if (hq_exp.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3 unexpected host_rvalid actual=0x%0h expected=none", host_rdata);
        end else chk(hq_tag.pop_front(), 32'(host_rdata), hq_exp.pop_front());
      end
      if (dp_valid) begin
        if (dq_exp.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 unexpected dp_valid actual=0x%0h expected=none", dp_coef);
        end else chk(dq_tag.pop_front(), 32'(dp_coef), dq_exp.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ptr_m[0] = '0; ptr_m[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 host_rvalid after reset", 32'(host_rvalid), 0);
    chk("R11 dp_valid after reset", 32'(dp_valid), 0);
    hr(0, 0, "R11 ptr0 reset"); step();
    hr(1, 0, "R11 ptr1 reset"); step();

    hw(0, 0, 8'hD5); step();
    hr(0, 0, "R1 ptr keeps 7 bits"); step();

    hw(0, 0, 8'h00); step();
    for (int i = 0; i < 100; i++) begin hw(0, 1, 8'(i * 7 + 3)); step(); end
    hr(0, 0, "R2 ptr after stream"); step();
    hw(1, 0, 8'h00); step();
    for (int i = 0; i < 100; i++) begin hw(1, 1, 8'(255 - i)); step(); end

    begin
      int sel[5] = '{0, 1, 3, 47, 99};
      foreach (sel[k]) begin
        hw(0, 0, 8'(sel[k])); step();
        hr(0, 1, "R3 data read"); step();
        hr(0, 1, "R3 repeat read same ptr"); step();
        hr(0, 0, "R3 ptr unchanged"); step();
      end
    end
    hw(1, 0, 8'd3); step();
    hr(1, 1, "R5 reserved bits masked"); step();
    hr(1, 0, "R8 filter1 ptr"); step();

    dpr(0, 2, 3, 0, "R4 coef f0 b2 c3"); step();
    dpr(1, 4, 4, 0, "R4 coef f1 b4 c4"); step();
    dpr(0, 0, 0, 0, "R9 coef f0 b0 c0");
    step();
    dpr(0, 5, 0, 0, "R9 band out of range"); step();
    dpr(1, 1, 7, 0, "R9 index out of range"); step();

    hw(0, 0, 8'd100); step();
    hw(0, 1, 8'hAA); step();
    hr(0, 0, "R7 ptr advanced past end"); step();
    hw(0, 0, 8'd100); step();
    hr(0, 1, "R7 unused byte reads zero"); step();

    hw(0, 0, 8'd127); step();
    hw(0, 1, 8'h55); step();
    hr(0, 0, "R6 ptr wrapped"); step();
    hr(0, 1, "R6 byte0 intact"); step();

    hw(0, 0, 8'd8); step();
    hw(0, 1, 8'h5A); dpr(0, 0, 2, 1, "R10 cancelled"); step();
    dpr(0, 0, 2, 0, "R10 new byte visible"); step();
    hw(0, 1, 8'hC3); dpr(1, 1, 1, 0, "R10 other filter proceeds"); step();
    dpr(0, 0, 2, 0, "R10 second write landed"); step();

    hw(0, 5, 8'h77); step();
    hr(0, 5, "R12 unused offset reads zero"); step();
    hr(0, 0, "R12 ptr untouched by unused offset"); step();
    hw(0, 0, 8'd20); host_rd = 1'b1; step();
    hr(0, 0, "R12 write wins over read"); step();

    repeat (4) step();
    while (hq_exp.size() > 0) begin
      checks++; fails++;
      $display("FAIL %s actual=missing expected=0x%0h", hq_tag.pop_front(), hq_exp.pop_front());
    end
    while (dq_exp.size() > 0) begin
      checks++; fails++;
      $display("FAIL %s actual=missing expected=0x%0h", dq_tag.pop_front(), dq_exp.pop_front());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule